// File: doc/BRIEF.md
# Conversion Scheduler with Threshold Alarms

This block drives a seven-channel, 16-bit measurement converter and keeps the latest result of every channel. A pass walks the enabled channels in ascending channel code, raising a one-cycle request for each and waiting for the converter's done strobe before it moves on. A pass is launched by a software start bit, which drops by itself once the pass has finished, by a continuous mode that starts passes back to back, or by a free-running period timer that fires once per second or once per minute.

Three comparators watch the stored results. Each one is tied to a channel chosen by a 3-bit code, and compares the upper 12 bits of that channel's result with a 12-bit threshold. A direction bit selects whether a value under or over the threshold counts as an alarm. Each comparator has a live status bit and a sticky flag. The flag sets when the comparison goes from not met to met, and a read strobe clears it. A flag that sets while its mask bit is clear drives the active-low interrupt low for a fixed number of cycles. Configuration writes arrive on a small strobe interface. The threshold and the channel code can be written separately, so reset values stay in place until they are overwritten.

Top module: `conv_scheduler`

## Requirements
- R1: After reset there is no conversion request, the start bit reads 0, all result slots read 0, all status and flag bits read 0, and `irq_n` is high.
- R2: With `rate_mode` = 00, a `start_set` pulse launches exactly one pass. The pass requests each enabled channel once, in ascending channel code. The result for channel code c (1..7) is stored in slot c-1 of `results`.
- R3: The start bit (`start_busy`) returns to 0 by itself when its pass completes. If no channel is enabled, it returns to 0 without any request being issued.
- R4: Only channels whose `ch_en` bit (bit c-1 for code c) is set are requested. The result slot of a disabled channel keeps its value.
- R5: With `rate_mode` = 01, a new pass starts as soon as the previous one ends, for as long as the mode is held. With `rate_mode` = 00 and no start bit, no request is issued.
- R6: With `rate_mode` = 10, a pass starts every CYC_PER_SEC cycles. With `rate_mode` = 11, a pass starts every CYC_PER_SEC*SEC_PER_MIN cycles.
- R7: Comparator channel code 000 means disabled, and codes 001..111 select general input, thermistor, battery voltage, charge current, input voltage, system voltage and input current. The comparison uses result bits 15:4. With direction 0 the condition is met when the value is strictly less than the threshold. With direction 1 it is met when the value is strictly greater. A disabled comparator, or a channel that has not been converted since reset, is never met.
- R8: The reset thresholds are 0x232, 0x389 and 0x000 for comparators 1, 2 and 3. The reset channel code is 010 for comparator 2 and 000 for the other two. All directions reset to 0.
- R9: A flag sets only on a not-met to met transition of its comparator. It stays set while the condition persists or goes away, and `flag_rd` clears all flags.
- R10: The interrupt mask bits reset to 1, 1, 0 for comparators 1, 2, 3 (1 = masked). A masked flag setting never moves `irq_n`.
- R11: An unmasked flag setting drives `irq_n` low for exactly IRQ_CYC cycles, starting in the cycle in which the flag becomes visible.
- R12: `conv_req` is high for one cycle per channel. The next request follows only after `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | 7 | Per-channel enable, bit c-1 for channel code c |
| start_set | input | 1 | Pulse that sets the start bit |
| rate_mode | input | 2 | 00 one pass on start, 01 continuous, 10 per second, 11 per minute |
| cmp_idx | input | 2 | Comparator addressed by a configuration write (0..2) |
| sel_we | input | 1 | Write the channel code of the addressed comparator |
| thr_we | input | 1 | Write the threshold and direction of the addressed comparator |
| wr_sel | input | 3 | Channel code to write |
| wr_thr | input | 12 | Threshold to write |
| wr_above | input | 1 | Direction to write: 0 below, 1 above |
| mask_we | input | 1 | Write all three interrupt mask bits |
| mask_wdata | input | 3 | Mask bits, bit k for comparator k+1 |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | 3 | Channel code of the current request |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 16 | Converter result, valid with `conv_done` |
| start_busy | output | 1 | Start bit readback |
| results | output | 7x16 | Latest result per channel, slot c-1 for code c |
| cmp_status | output | 3 | Live comparator condition |
| cmp_flag | output | 3 | Sticky comparator flags |
| flag_rd | input | 1 | Flag read strobe, clears all flags |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
A wrong channel pointer or enable snapshot shows up at `conv_ch` in the very next request, and a misplaced result shows in the wrong slot of `results` one cycle after `conv_done`. A timer or rate-mode error shifts the spacing between requests, so it can be seen from the second periodic pass onward. A comparator that uses the wrong bits, threshold or direction shows in `cmp_status` one cycle after the result is stored. Lost edge tracking shows as a flag or an `irq_n` pulse with no fresh crossing behind it, in that same cycle.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
    localparam int NCH  = 7;
    localparam int DW   = 16;
    localparam int TW   = 12;
    localparam int NCMP = 3;
    localparam int SELW = 3;
    localparam int IDXW = $clog2(NCMP);

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_st_e;
    typedef enum logic [1:0] {RATE_ONCE = 2'd0, RATE_CONT = 2'd1,
                              RATE_SEC = 2'd2, RATE_MIN = 2'd3} rate_e;

    typedef struct packed {
        logic [SELW-1:0] sel;
        logic [TW-1:0]   thr;
        logic            above;
    } cmp_cfg_t;

    function automatic logic [TW-1:0] thr_at_reset(input int k);
        case (k)
            0:       return 12'h232;
            1:       return 12'h389;
            default: return 12'h000;
        endcase
    endfunction

    function automatic logic [SELW-1:0] sel_at_reset(input int k);
        return (k == 1) ? 3'b010 : 3'b000;
    endfunction
endpackage

// File: rtl/cmp_cfg_regs.sv
module cmp_cfg_regs
    import conv_sched_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDXW-1:0]            cmp_idx,
    input  logic                       sel_we,
    input  logic                       thr_we,
    input  logic [SELW-1:0]            wr_sel,
    input  logic [TW-1:0]              wr_thr,
    input  logic                       wr_above,
    input  logic                       mask_we,
    input  logic [NCMP-1:0]            mask_wdata,
    output cmp_cfg_t [NCMP-1:0]        cfg,
    output logic [NCMP-1:0]            mask
);
    typedef struct packed {
        cmp_cfg_t [NCMP-1:0] cfg;
        logic [NCMP-1:0]     mask;
    } regs_t;

    function automatic regs_t regs_init();
        regs_t r;
        for (int k = 0; k < NCMP; k++) begin
            r.cfg[k].sel   = sel_at_reset(k);
            r.cfg[k].thr   = thr_at_reset(k);
            r.cfg[k].above = 1'b0;
            r.mask[k]      = (k < 2);
        end
        return r;
    endfunction

    localparam regs_t REGS_RST = regs_init();

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int k = 0; k < NCMP; k++) begin
            if (cmp_idx == IDXW'(k)) begin
                if (sel_we) regs_d.cfg[k].sel = wr_sel;
                if (thr_we) begin
                    regs_d.cfg[k].thr   = wr_thr;
                    regs_d.cfg[k].above = wr_above;
                end
            end
        end
        if (mask_we) regs_d.mask = mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign cfg  = regs_q.cfg;
    assign mask = regs_q.mask;
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_sched_pkg::*;
#(
    parameter int CYC_PER_SEC = 1000000,
    parameter int SEC_PER_MIN = 60
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            ch_en,
    input  logic                      start_set,
    input  logic [1:0]                rate_mode,
    input  logic                      conv_done,
    input  logic [DW-1:0]             conv_data,
    output logic                      conv_req,
    output logic [SELW-1:0]           conv_ch,
    output logic                      start_busy,
    output logic [NCH-1:0][DW-1:0]    results,
    output logic [NCH-1:0]            res_valid
);
    localparam int MIN_CYC = CYC_PER_SEC * SEC_PER_MIN;
    localparam int TMW     = $clog2(MIN_CYC + 1);
    localparam logic [TMW-1:0] SEC_LAST = TMW'(CYC_PER_SEC - 1);
    localparam logic [TMW-1:0] MIN_LAST = TMW'(MIN_CYC - 1);

    typedef struct packed {
        seq_st_e                st;
        logic [SELW-1:0]        ch;
        logic [NCH-1:0]         en_snap;
        logic                   start;
        logic [TMW-1:0]         tmr;
        logic                   pend;
        logic [NCH-1:0][DW-1:0] res;
        logic [NCH-1:0]         valid;
    } seq_t;

    seq_t q, d;

    // lowest enabled channel code above 'from', 0 when none is left
    function automatic logic [SELW-1:0] next_en(input logic [NCH-1:0] en,
                                                input logic [SELW-1:0] from);
        logic [SELW-1:0] r;
        r = '0;
        for (int c = NCH; c >= 1; c--) begin
            if (SELW'(c) > from && en[c-1]) r = SELW'(c);
        end
        return r;
    endfunction

    logic [SELW-1:0] nxt;
    logic [SELW-1:0] slot;
    logic [TMW-1:0]  tmr_last;
    logic            periodic;

    always_comb begin
        d        = q;
        nxt      = '0;
        slot     = q.ch - SELW'(1);
        periodic = (rate_mode == RATE_SEC) || (rate_mode == RATE_MIN);
        tmr_last = (rate_mode == RATE_MIN) ? MIN_LAST : SEC_LAST;

        if (start_set) d.start = 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (q.start || rate_mode == RATE_CONT || q.pend) begin
                    d.en_snap = ch_en;
                    d.pend    = 1'b0;
                    nxt       = next_en(ch_en, '0);
                    if (nxt == '0) begin
                        d.start = 1'b0;
                    end else begin
                        d.ch = nxt;
                        d.st = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: d.st = ST_WAIT;
            ST_WAIT: begin
                if (conv_done) begin
                    d.res[slot]   = conv_data;
                    d.valid[slot] = 1'b1;
                    nxt = next_en(q.en_snap, q.ch);
                    if (nxt == '0) begin
                        d.st    = ST_IDLE;
                        d.start = 1'b0;
                    end else begin
                        d.ch = nxt;
                        d.st = ST_ISSUE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // period timer runs last so a tick is never lost to a pass launch
        if (periodic) begin
            if (q.tmr >= tmr_last) begin
                d.tmr  = '0;
                d.pend = 1'b1;
            end else begin
                d.tmr = q.tmr + TMW'(1);
            end
        end else begin
            d.tmr  = '0;
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.ch      <= '0;
            q.en_snap <= '0;
            q.start   <= 1'b0;
            q.tmr     <= '0;
            q.pend    <= 1'b0;
            q.res     <= '0;
            q.valid   <= '0;
        end else begin
            q <= d;
        end
    end

    assign conv_req   = (q.st == ST_ISSUE);
    assign conv_ch    = q.ch;
    assign start_busy = q.start;
    assign results    = q.res;
    assign res_valid  = q.valid;

    // R12
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R4
    req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (conv_ch != '0) && q.en_snap[conv_ch - SELW'(1)]);

    // R3
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_busy) |-> q.st == ST_IDLE);

    // R6
    tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.tmr <= MIN_LAST);
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import conv_sched_pkg::*;
#(
    parameter int IRQ_CYC = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0][DW-1:0]    results,
    input  logic [NCH-1:0]            res_valid,
    input  cmp_cfg_t [NCMP-1:0]       cfg,
    input  logic [NCMP-1:0]           mask,
    input  logic                      flag_rd,
    output logic [NCMP-1:0]           cmp_status,
    output logic [NCMP-1:0]           cmp_flag,
    output logic                      irq_n
);
    localparam int CW = $clog2(IRQ_CYC + 1);

    typedef struct packed {
        logic [NCMP-1:0] status;
        logic [NCMP-1:0] flag;
        logic [CW-1:0]   cnt;
        logic            irq_n;
    } alarm_t;

    alarm_t q, d;
    logic [NCMP-1:0] met;
    logic [NCMP-1:0] newset;

    always_comb begin
        logic [SELW-1:0] idx;
        logic [TW-1:0]   v;
        d = q;
        for (int k = 0; k < NCMP; k++) begin
            met[k] = 1'b0;
            idx    = cfg[k].sel - SELW'(1);
            v      = results[idx][DW-1 -: TW];
            if (cfg[k].sel != '0 && res_valid[idx]) begin
                met[k] = cfg[k].above ? (v > cfg[k].thr) : (v < cfg[k].thr);
            end
        end
        newset   = met & ~q.status;
        d.status = met;
        d.flag   = (q.flag & ~{NCMP{flag_rd}}) | newset;
        if (|(newset & ~mask))      d.cnt = CW'(IRQ_CYC);
        else if (q.cnt != '0)       d.cnt = q.cnt - CW'(1);
        d.irq_n = (d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.status <= '0;
            q.flag   <= '0;
            q.cnt    <= '0;
            q.irq_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cmp_status = q.status;
    assign cmp_flag   = q.flag;
    assign irq_n      = q.irq_n;

    for (genvar k = 0; k < NCMP; k++) begin : g_chk
        // R9
        flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q.flag[k]) |-> $rose(q.status[k]));

        // R7
        off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(cfg[k].sel) == '0) |-> !q.status[k]);
    end

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> |(q.status & ~$past(q.status) & ~$past(mask)));
endmodule

// File: rtl/conv_scheduler.sv
module conv_scheduler
    import conv_sched_pkg::*;
#(
    parameter int CYC_PER_SEC = 1000000,
    parameter int SEC_PER_MIN = 60,
    parameter int IRQ_CYC     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            ch_en,
    input  logic                      start_set,
    input  logic [1:0]                rate_mode,
    input  logic [IDXW-1:0]           cmp_idx,
    input  logic                      sel_we,
    input  logic                      thr_we,
    input  logic [SELW-1:0]           wr_sel,
    input  logic [TW-1:0]             wr_thr,
    input  logic                      wr_above,
    input  logic                      mask_we,
    input  logic [NCMP-1:0]           mask_wdata,
    output logic                      conv_req,
    output logic [SELW-1:0]           conv_ch,
    input  logic                      conv_done,
    input  logic [DW-1:0]             conv_data,
    output logic                      start_busy,
    output logic [NCH-1:0][DW-1:0]    results,
    output logic [NCMP-1:0]           cmp_status,
    output logic [NCMP-1:0]           cmp_flag,
    input  logic                      flag_rd,
    output logic                      irq_n
);
    cmp_cfg_t [NCMP-1:0] cfg;
    logic [NCMP-1:0]     mask;
    logic [NCH-1:0]      res_valid;

    cmp_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_idx    (cmp_idx),
        .sel_we     (sel_we),
        .thr_we     (thr_we),
        .wr_sel     (wr_sel),
        .wr_thr     (wr_thr),
        .wr_above   (wr_above),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .cfg        (cfg),
        .mask       (mask)
    );

    conv_seq #(
        .CYC_PER_SEC (CYC_PER_SEC),
        .SEC_PER_MIN (SEC_PER_MIN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_en      (ch_en),
        .start_set  (start_set),
        .rate_mode  (rate_mode),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .conv_req   (conv_req),
        .conv_ch    (conv_ch),
        .start_busy (start_busy),
        .results    (results),
        .res_valid  (res_valid)
    );

    alarm_unit #(
        .IRQ_CYC (IRQ_CYC)
    ) u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .results    (results),
        .res_valid  (res_valid),
        .cfg        (cfg),
        .mask       (mask),
        .flag_rd    (flag_rd),
        .cmp_status (cmp_status),
        .cmp_flag   (cmp_flag),
        .irq_n      (irq_n)
    );
endmodule

// File: tb/conv_scheduler_test.sv
`timescale 1ns/1ps
module conv_scheduler_test;
    localparam int CPS = 40;
    localparam int SPM = 3;
    localparam int IRQ = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] ch_en = '0;
    logic start_set = 0, sel_we = 0, thr_we = 0, wr_above = 0, mask_we = 0, flag_rd = 0;
    logic [1:0] rate_mode = '0, cmp_idx = '0;
    logic [2:0] wr_sel = '0, mask_wdata = '0;
    logic [11:0] wr_thr = '0;
    logic conv_req, conv_done = 1'b0, start_busy, irq_n;
    logic [2:0] conv_ch;
    logic [15:0] conv_data = '0;
    logic [6:0][15:0] results;
    logic [2:0] cmp_status, cmp_flag;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    conv_scheduler #(.CYC_PER_SEC(CPS), .SEC_PER_MIN(SPM), .IRQ_CYC(IRQ)) uut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .start_set(start_set),
        .rate_mode(rate_mode), .cmp_idx(cmp_idx), .sel_we(sel_we), .thr_we(thr_we),
        .wr_sel(wr_sel), .wr_thr(wr_thr), .wr_above(wr_above), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .conv_req(conv_req), .conv_ch(conv_ch),
        .conv_done(conv_done), .conv_data(conv_data), .start_busy(start_busy),
        .results(results), .cmp_status(cmp_status), .cmp_flag(cmp_flag),
        .flag_rd(flag_rd), .irq_n(irq_n));

    // converter model: answers each request after three cycles
    logic [15:0] model_val [1:7];
    logic [2:0]  pend_ch = '0;
    int          lat = 0;
    int          cyc = 0;
    int          ord_n = 0;
    int          ord_ch [0:1023];
    int          ord_cyc [0:1023];
    int          irq_low = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        conv_done <= 1'b0;
        if (conv_req) begin
            pend_ch <= conv_ch;
            lat     <= 3;
            if (ord_n < 1024) begin
                ord_ch[ord_n]  <= int'(conv_ch);
                ord_cyc[ord_n] <= cyc;
            end
            ord_n <= ord_n + 1;
        end else if (lat > 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                conv_done <= 1'b1;
                conv_data <= model_val[pend_ch];
            end
        end
    end

    always @(negedge clk) if (rst_n && !irq_n) irq_low = irq_low + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_pass(input logic [6:0] en);
        int guard = 0;
        ch_en = en;
        @(negedge clk) start_set = 1'b1;
        @(negedge clk) start_set = 1'b0;
        while (start_busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic wr_cmp_sel(input int k, input logic [2:0] s);
        @(negedge clk) begin cmp_idx = 2'(k); wr_sel = s; sel_we = 1'b1; end
        @(negedge clk) sel_we = 1'b0;
    endtask

    task automatic wr_cmp_thr(input int k, input logic [11:0] t, input logic ab);
        @(negedge clk) begin cmp_idx = 2'(k); wr_thr = t; wr_above = ab; thr_we = 1'b1; end
        @(negedge clk) thr_we = 1'b0;
    endtask

    task automatic read_flags();
        @(negedge clk) flag_rd = 1'b1;
        @(negedge clk) flag_rd = 1'b0;
    endtask

    task automatic t_reset();
        check(!conv_req && !start_busy, "R1 idle after reset", {conv_req, start_busy}, 0);
        check(results == '0, "R1 results zero", results[0], 0);
        check(cmp_status == 0 && cmp_flag == 0, "R1 status/flags zero", {cmp_status, cmp_flag}, 0);
        check(irq_n == 1'b1, "R1 irq high", irq_n, 1);
    endtask

    task automatic t_oneshot();
        int base = ord_n;
        model_val[3] = 16'h1234;
        model_val[5] = 16'hABCD;
        run_pass(7'b0010100);
        check(ord_n - base == 2, "R2 request count", ord_n - base, 2);
        check(ord_ch[base] == 3, "R2 first channel", ord_ch[base], 3);
        check(ord_ch[base+1] == 5, "R2 second channel", ord_ch[base+1], 5);
        check(results[2] == 16'h1234, "R2 slot code3", results[2], 16'h1234);
        check(results[4] == 16'hABCD, "R2 slot code5", results[4], 16'hABCD);
        check(results[0] == 16'h0 && results[3] == 16'h0, "R4 disabled slots unchanged", results[0], 0);
        check(!start_busy, "R3 start cleared", start_busy, 0);
        repeat (50) @(negedge clk);
        check(ord_n - base == 2, "R2 single pass only", ord_n - base, 2);
    endtask

    task automatic t_empty();
        int base = ord_n;
        ch_en = '0;
        @(negedge clk) start_set = 1'b1;
        @(negedge clk) start_set = 1'b0;
        repeat (3) @(negedge clk);
        check(!start_busy, "R3 empty pass clears start", start_busy, 0);
        check(ord_n == base, "R3 empty pass no request", ord_n - base, 0);
    endtask

    task automatic t_cont();
        int base;
        model_val[1] = 16'h0100;
        ch_en = 7'b0000001;
        base = ord_n;
        @(negedge clk) rate_mode = 2'b01;
        repeat (100) @(negedge clk);
        check(ord_n - base >= 10, "R5 continuous passes", ord_n - base, 10);
        check(results[0] == 16'h0100, "R5 continuous result", results[0], 16'h0100);
        rate_mode = 2'b00;
        repeat (20) @(negedge clk);
        base = ord_n;
        repeat (40) @(negedge clk);
        check(ord_n == base, "R5 one-shot mode idle", ord_n - base, 0);
    endtask

    task automatic t_periodic(input logic [1:0] m, input int period, input int wait_cyc, input string tag);
        int base, mn, mx;
        base = ord_n;
        @(negedge clk) rate_mode = m;
        repeat (wait_cyc) @(negedge clk);
        rate_mode = 2'b00;
        mn = 1 << 30;
        mx = 0;
        for (int i = base + 1; i < ord_n; i++) begin
            int iv = ord_cyc[i] - ord_cyc[i-1];
            if (iv < mn) mn = iv;
            if (iv > mx) mx = iv;
        end
        check(ord_n - base >= 3, {tag, " pass count"}, ord_n - base, 3);
        check(mn == period && mx == period, {tag, " pass spacing"}, mx, period);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset_thr();
        int ib = irq_low;
        model_val[2] = 16'h3880;
        run_pass(7'b0000010);
        check(cmp_status[1] && cmp_flag[1], "R8 comp2 thermistor below 0x389", {cmp_status[1], cmp_flag[1]}, 3);
        model_val[2] = 16'h3890;
        run_pass(7'b0000010);
        check(!cmp_status[1], "R7 equal not below", cmp_status[1], 0);
        check(cmp_flag[1], "R9 flag sticky", cmp_flag[1], 1);
        read_flags();
        @(negedge clk);
        check(cmp_flag == 3'b000, "R9 read clears flags", cmp_flag, 0);
        wr_cmp_sel(0, 3'b001);
        model_val[1] = 16'h2320;
        run_pass(7'b0000001);
        check(!cmp_status[0], "R8 comp1 threshold 0x232 upper", cmp_status[0], 0);
        model_val[1] = 16'h2310;
        run_pass(7'b0000001);
        check(cmp_status[0] && cmp_flag[0], "R8 comp1 threshold 0x232 met", cmp_status[0], 1);
        check(!cmp_status[2], "R7 comp3 disabled never met", cmp_status[2], 0);
        check(irq_low == ib, "R10 reset masks hold irq", irq_low - ib, 0);
        read_flags();
    endtask

    task automatic t_above();
        int ib;
        wr_cmp_sel(2, 3'b011);
        wr_cmp_thr(2, 12'h800, 1'b1);
        model_val[3] = 16'h8000;
        run_pass(7'b0000100);
        check(!cmp_status[2], "R7 equal not above", cmp_status[2], 0);
        ib = irq_low;
        model_val[3] = 16'h8010;
        run_pass(7'b0000100);
        repeat (8) @(negedge clk);
        check(cmp_status[2] && cmp_flag[2], "R7 above met", {cmp_status[2], cmp_flag[2]}, 3);
        check(irq_low - ib == IRQ, "R11 irq pulse width", irq_low - ib, IRQ);
    endtask

    task automatic t_reflag();
        int ib;
        read_flags();
        @(negedge clk);
        check(cmp_flag[2] == 1'b0, "R9 flag cleared", cmp_flag[2], 0);
        ib = irq_low;
        run_pass(7'b0000100);
        repeat (8) @(negedge clk);
        check(!cmp_flag[2] && irq_low == ib, "R9 no new flag without transition", cmp_flag[2], 0);
        model_val[3] = 16'h7000;
        run_pass(7'b0000100);
        check(!cmp_status[2], "R7 below threshold in above mode", cmp_status[2], 0);
        model_val[3] = 16'h8010;
        run_pass(7'b0000100);
        check(cmp_flag[2], "R9 flag sets on new crossing", cmp_flag[2], 1);
    endtask

    task automatic t_mask();
        int ib;
        @(negedge clk) begin mask_we = 1'b1; mask_wdata = 3'b111; end
        @(negedge clk) mask_we = 1'b0;
        read_flags();
        model_val[3] = 16'h7000;
        run_pass(7'b0000100);
        ib = irq_low;
        model_val[3] = 16'h8010;
        run_pass(7'b0000100);
        repeat (8) @(negedge clk);
        check(cmp_flag[2] && irq_low == ib, "R10 masked flag no irq", irq_low - ib, 0);
        @(negedge clk) begin mask_we = 1'b1; mask_wdata = 3'b101; end
        @(negedge clk) mask_we = 1'b0;
        ib = irq_low;
        model_val[2] = 16'h3000;
        run_pass(7'b0000010);
        repeat (8) @(negedge clk);
        check(irq_low - ib == IRQ, "R11 unmasked comp2 irq", irq_low - ib, IRQ);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int c = 1; c <= 7; c++) model_val[c] = 16'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_empty();
        t_cont();
        t_periodic(2'b10, CPS, 200, "R6 second");
        t_periodic(2'b11, CPS * SPM, 400, "R6 minute");
        t_reset_thr();
        t_above();
        t_reflag();
        t_mask();
        report();
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
        report();
    end
endmodule